// File: doc/BRIEF.md
# Sharpness-Driven Subcarrier Phase Tracker

This block finds, by slow trial and error, the subcarrier phase offset that gives the sharpest reconstructed luma. A stream of luma samples arrives with a per-sample valid flag that marks active video. The block passes the active samples through a three-tap high-pass kernel and squares each filter output. Squaring rectifies the output and gives steep edges extra weight. The squares are summed over the field, and the total is the edge energy of that field.

At every field strobe the finished total is published and the sum restarts. The published total is compared with the total of the previous field. The signed phase offset then moves by one fixed step. If the energy fell, the direction of travel reverses; otherwise it stays the same. The offset is added outside the block to the phase recovered from the input, and it drives the remodulation of the recovered high-frequency luma. Convergence takes many fields, which suits a phase that drifts slowly. A hold input freezes the offset, for example while the source is unstable.

Top module: `sharp_phase_tracker`

## Requirements
- R1: After reset, `phase_off_o` is 0 and `energy_o` is 0.
- R2: For three consecutive active samples a, b, c of one field, the field energy gains (2b − a − c)². The first two active samples of a field add nothing.
- R3: Only samples with `luma_vld_i` high are filtered and summed. Idle cycles between active samples neither add a term nor break the three-sample window.
- R4: `energy_o` takes the completed field total at the clock edge that samples `field_strb_i`, and holds it until the next strobe. This total includes the term of a sample taken in the cycle just before the strobe. A sample that is active in the strobe cycle is the first sample of the new field.
- R5: The field total saturates at 2^ACC_W − 1 and never wraps.
- R6: Two clock edges after the strobe edge, the offset moves by exactly STEP. After reset the first move is upward (+STEP).
- R7: If the new field energy is strictly lower than the previous field energy, the direction reverses before the step is applied. If it is equal or higher, the direction is kept.
- R8: The offset is a two's-complement PHASE_W-bit value that wraps modulo 2^PHASE_W, so +STEP from 120 gives −128 when PHASE_W = 8 and STEP = 8.
- R9: If `hold_i` is high in the strobe cycle, neither the offset nor the direction changes for that field. The field energy is still published and still becomes the reference for the next comparison.
- R10: The offset changes only on the edge two cycles after a strobe that was not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| luma_i | input | LUMA_W | Luma sample, unsigned |
| luma_vld_i | input | 1 | Marks the sample as active video |
| field_strb_i | input | 1 | One-cycle pulse that closes a field |
| hold_i | input | 1 | Sampled with the strobe; freezes the offset step |
| phase_off_o | output | PHASE_W | Signed subcarrier phase offset |
| energy_o | output | ACC_W | Edge energy of the last completed field |

## Verification
Closing a field and adding its last squared term can happen in the same cycle. A sample is driven in the cycle right before the strobe, and its filter term reaches the accumulator during the strobe cycle itself. An active sample can also be driven together with the strobe, and it must open the next field. These cases are judged by comparing `energy_o` for both fields against an arithmetic sum in the bench. The sum places the boundary sample in the new field. Saturation and the reversal decision are provoked in the same run by sequences of fields with chosen energies.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

   function automatic dir_e dir_flip(input dir_e d);
      return (d == DIR_UP) ? DIR_DOWN : DIR_UP;
   endfunction
endpackage

// File: rtl/sp_hpf.sv
module sp_hpf #(
   parameter int LUMA_W = 8,
   parameter int HP_W   = LUMA_W + 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [LUMA_W-1:0]      smp_i,
   input  logic                   smp_vld_i,
   input  logic                   fld_strb_i,
   output logic                   hp_vld_o,
   output logic signed [HP_W-1:0] hp_o
);
   localparam int NHIST = 2;
   localparam int FILL_W = $clog2(NHIST + 1);

   if (HP_W < LUMA_W + 2) begin : g_bad_hp_w
      $error("sp_hpf: HP_W too narrow for kernel gain");
   end

   logic [LUMA_W-1:0] hist_q [NHIST];
   logic [FILL_W-1:0] fill_q;
   logic signed [HP_W-1:0] kern;

   always_comb begin
      kern = ($signed({2'b00, hist_q[0]}) <<< 1)
             - $signed({2'b00, hist_q[1]})
             - $signed({2'b00, smp_i});
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q[0] <= '0;
      end else if (smp_vld_i) begin
         hist_q[0] <= smp_i;
      end
   end

   for (genvar g = 1; g < NHIST; g++) begin : g_hist
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hist_q[g] <= '0;
         end else if (smp_vld_i && !fld_strb_i) begin
            hist_q[g] <= hist_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fill_q   <= '0;
         hp_vld_o <= 1'b0;
         hp_o     <= '0;
      end else begin
         hp_vld_o <= 1'b0;
         if (fld_strb_i) begin
            fill_q <= smp_vld_i ? FILL_W'(1) : '0;
         end else if (smp_vld_i) begin
            if (fill_q == FILL_W'(NHIST)) begin
               hp_vld_o <= 1'b1;
               hp_o     <= kern;
            end else begin
               fill_q <= fill_q + FILL_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/sp_energy.sv
module sp_energy #(
   parameter int HP_W  = 10,
   parameter int ACC_W = 24
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   hp_vld_i,
   input  logic signed [HP_W-1:0] hp_i,
   input  logic                   fld_strb_i,
   output logic [ACC_W-1:0]       acc_o,
   output logic [ACC_W-1:0]       energy_o,
   output logic                   energy_upd_o
);
   localparam int SQ_W = 2 * HP_W;

   if (ACC_W < SQ_W) begin : g_bad_acc_w
      $error("sp_energy: ACC_W must hold at least one squared term");
   end

   logic [SQ_W-1:0]  sq;
   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] sum_sat;

   always_comb begin
      sq      = SQ_W'(hp_i * hp_i);
      sum     = {1'b0, acc_o} + (hp_vld_i ? (ACC_W+1)'(sq) : '0);
      sum_sat = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_o        <= '0;
         energy_o     <= '0;
         energy_upd_o <= 1'b0;
      end else begin
         energy_upd_o <= fld_strb_i;
         if (fld_strb_i) begin
            energy_o <= sum_sat;
            acc_o    <= '0;
         end else begin
            acc_o    <= sum_sat;
         end
      end
   end
endmodule

// File: rtl/sp_climb.sv
module sp_climb
   import sp_pkg::*;
#(
   parameter int ACC_W   = 24,
   parameter int PHASE_W = 8,
   parameter int STEP    = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               upd_i,
   input  logic               hold_i,
   input  logic [ACC_W-1:0]   energy_i,
   output logic [PHASE_W-1:0] phase_off_o
);
   if (PHASE_W < 2) begin : g_bad_phase_w
      $error("sp_climb: PHASE_W must be at least 2");
   end
   if (STEP < 1 || STEP >= (1 << (PHASE_W - 1))) begin : g_bad_step
      $error("sp_climb: STEP must lie within half a phase cycle");
   end

   localparam logic [PHASE_W-1:0] STEP_V = PHASE_W'(STEP);

   logic [ACC_W-1:0] ref_q;
   logic             ref_ok_q;
   dir_e             dir_q, dir_nx;

   always_comb begin
      dir_nx = (ref_ok_q && (energy_i < ref_q)) ? dir_flip(dir_q) : dir_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q       <= '0;
         ref_ok_q    <= 1'b0;
         dir_q       <= DIR_UP;
         phase_off_o <= '0;
      end else if (upd_i) begin
         ref_q    <= energy_i;
         ref_ok_q <= 1'b1;
         if (!hold_i) begin
            dir_q       <= dir_nx;
            phase_off_o <= (dir_nx == DIR_UP) ? phase_off_o + STEP_V
                                              : phase_off_o - STEP_V;
         end
      end
   end
endmodule

// File: rtl/sharp_phase_tracker.sv
module sharp_phase_tracker #(
   parameter int LUMA_W  = 8,
   parameter int ACC_W   = 24,
   parameter int PHASE_W = 8,
   parameter int STEP    = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [LUMA_W-1:0]  luma_i,
   input  logic               luma_vld_i,
   input  logic               field_strb_i,
   input  logic               hold_i,
   output logic [PHASE_W-1:0] phase_off_o,
   output logic [ACC_W-1:0]   energy_o
);
   localparam int HP_W = LUMA_W + 2;

   if (LUMA_W < 2) begin : g_bad_luma_w
      $error("sharp_phase_tracker: LUMA_W must be at least 2");
   end

   logic                   hp_vld;
   logic signed [HP_W-1:0] hp;
   logic [ACC_W-1:0]       acc_run;
   logic                   energy_upd;
   logic                   hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= 1'b0;
      else         hold_q <= hold_i;
   end

   sp_hpf #(.LUMA_W(LUMA_W), .HP_W(HP_W)) u_hpf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_i      (luma_i),
      .smp_vld_i  (luma_vld_i),
      .fld_strb_i (field_strb_i),
      .hp_vld_o   (hp_vld),
      .hp_o       (hp)
   );

   sp_energy #(.HP_W(HP_W), .ACC_W(ACC_W)) u_energy (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .hp_vld_i     (hp_vld),
      .hp_i         (hp),
      .fld_strb_i   (field_strb_i),
      .acc_o        (acc_run),
      .energy_o     (energy_o),
      .energy_upd_o (energy_upd)
   );

   sp_climb #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .STEP(STEP)) u_climb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .upd_i       (energy_upd),
      .hold_i      (hold_q),
      .energy_i    (energy_o),
      .phase_off_o (phase_off_o)
   );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
   parameter int ACC_W   = 24,
   parameter int PHASE_W = 8,
   parameter int STEP    = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               field_strb_i,
   input logic               hold_i,
   input logic [PHASE_W-1:0] phase_off_o,
   input logic [ACC_W-1:0]   energy_o,
   input logic [ACC_W-1:0]   acc_run
);
   AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_off_o != $past(phase_off_o)) |->
         ((PHASE_W'(phase_off_o - $past(phase_off_o)) == PHASE_W'(STEP)) ||
          (PHASE_W'($past(phase_off_o) - phase_off_o) == PHASE_W'(STEP)))); // R6

   AST_STEP_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_off_o != $past(phase_off_o)) |->
         ($past(field_strb_i, 2) && !$past(hold_i, 2))); // R10

   AST_ENERGY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(field_strb_i) |-> $stable(energy_o)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(field_strb_i) |-> (acc_run >= $past(acc_run))); // R5

   AST_FIELD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      field_strb_i |=> (acc_run == '0)); // R4
endmodule

bind sharp_phase_tracker sp_checker #(
   .ACC_W(ACC_W), .PHASE_W(PHASE_W), .STEP(STEP)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .field_strb_i (field_strb_i),
   .hold_i       (hold_i),
   .phase_off_o  (phase_off_o),
   .energy_o     (energy_o),
   .acc_run      (acc_run)
);

// File: tb/sharp_phase_tracker_tb_top.sv
module sharp_phase_tracker_tb_top;
   localparam int LUMA_W  = 8;
   localparam int ACC_W   = 20;
   localparam int PHASE_W = 8;
   localparam int STEP    = 8;
   localparam longint MAXE = (64'd1 << ACC_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LUMA_W-1:0]  luma = '0;
   logic               vld = 1'b0, strb = 1'b0, hold = 1'b0;
   logic [PHASE_W-1:0] off;
   logic [ACC_W-1:0]   energy;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sharp_phase_tracker #(.LUMA_W(LUMA_W), .ACC_W(ACC_W), .PHASE_W(PHASE_W), .STEP(STEP)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .luma_i(luma), .luma_vld_i(vld),
      .field_strb_i(strb), .hold_i(hold), .phase_off_o(off), .energy_o(energy));

   // reference model state
   longint m_x1 = 0, m_x2 = 0, m_acc = 0, m_prev = 0, m_energy = 0;
   int m_fill = 0, m_off = 0;
   bit m_ref = 0, m_down = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input bit v, input int x, input bit s, input bit h);
      longint t;
      @(negedge clk);
      vld = v; luma = LUMA_W'(x); strb = s; hold = h;
      if (s) begin
         m_energy = m_acc;
         m_acc = 0;
         if (!h) begin
            if (m_ref && (m_energy < m_prev)) m_down = !m_down;
            m_off = (m_off + (m_down ? -STEP : STEP)) & ((1 << PHASE_W) - 1);
         end
         m_prev = m_energy;
         m_ref = 1;
         m_fill = v ? 1 : 0;
         if (v) m_x1 = x;
      end else if (v) begin
         if (m_fill == 2) begin
            t = 2 * m_x1 - m_x2 - x;
            m_acc = m_acc + t * t;
            if (m_acc > MAXE) m_acc = MAXE;
         end else begin
            m_fill++;
         end
         m_x2 = m_x1;
         m_x1 = x;
      end
   endtask

   task automatic close_field(input bit h, input string req);
      cyc(0, 0, 1, h);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk({req, " energy"}, longint'(energy), m_energy);
      chk({req, " offset"}, longint'(off), longint'(m_off));
   endtask

   task automatic impulse(input int amp, input int gap);
      for (int i = 0; i < 5; i++) begin
         cyc(1, (i == 2) ? amp : 0, 0, 0);
         for (int g = 0; g < gap; g++) cyc(0, 77, 0, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 offset after reset", longint'(off), 0);
      chk("R1 energy after reset", longint'(energy), 0);

      // R2/R6: linear ramp has zero energy, first step goes up
      for (int i = 0; i < 10; i++) cyc(1, 20 * i, 0, 0);
      close_field(0, "R2 R6 ramp");
      chk("R6 first step +STEP", longint'(off), STEP);

      // R2: impulse energy 10000+40000+10000
      impulse(100, 0);
      close_field(0, "R2 impulse");
      chk("R2 impulse literal", longint'(energy), 60000);

      // R3/R7: same impulse with idle gaps, equal energy keeps direction
      impulse(100, 3);
      close_field(0, "R3 R7 gaps equal");
      chk("R7 equal keeps dir", longint'(off), 3 * STEP);

      // R7: lower energy reverses
      impulse(50, 1);
      close_field(0, "R7 reverse");
      chk("R7 reversed offset", longint'(off), 2 * STEP);

      // R5: alternating full scale saturates
      for (int i = 0; i < 12; i++) cyc(1, (i % 2) ? 255 : 0, 0, 0);
      close_field(0, "R5 saturate");
      chk("R5 saturation value", longint'(energy), MAXE);

      // R9: held field with flat luma
      for (int i = 0; i < 8; i++) cyc(1, 90, 0, 0);
      close_field(1, "R9 hold");
      chk("R9 offset frozen", longint'(off), STEP);
      impulse(100, 0);
      close_field(0, "R9 after hold");

      // R4: last sample just before strobe, strobe carries first sample of next field
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 100, 0, 0);
      cyc(1, 100, 1, 0);
      cyc(1, 0, 0, 0);
      cyc(1, 0, 0, 0);
      chk("R4 boundary energy", longint'(energy), m_energy);
      chk("R4 boundary energy literal", longint'(energy), 10000);
      close_field(0, "R4 next field");
      chk("R4 next field literal", longint'(energy), 10000);

      // R8: rising energy fields drive the offset across the wrap point
      for (int k = 1; k <= 20; k++) begin
         impulse(10 * k, 0);
         close_field(0, "R8 wrap");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule